// File: doc/BRIEF.md
# Sixteen-bit Integer Divide Unit with Divide-Error Detection

The block divides a double-width dividend by a single-width divisor, in unsigned or two's-complement mode. The dividend is built from two half words: an upper data word and a lower accumulator word. A caller pulses `start_i` with the operands. Some cycles later the block raises `done_o` for one cycle. In that cycle it shows either a quotient and a remainder or a divide-error flag. When the flag is set, the caller must not write anything back. The quotient is meant for the accumulator register and the remainder for the data register.

Three conditions raise the error:
- a zero divisor;
- the signed case of the most negative dividend divided by minus one;
- any quotient that does not fit the half-word range of the selected mode.

The first two are found when the operands are accepted, and the block reports them on the next cycle. All other operations run a restoring shift-subtract on operand magnitudes. The signs are applied and the range is checked at the end. The block leaves the arithmetic flags alone.

Top module: `divx_unit`

## Requirements
- R1: The dividend is `{dvd_hi_i, dvd_lo_i}`, with the high word in the upper half. With `signed_i`=0, a non-faulting operation returns quotient = floor(dividend / divisor) and remainder = dividend − quotient·divisor.
- R2: With `signed_i`=1, operands are two's complement. The quotient truncates toward zero. A non-zero remainder carries the sign of the dividend.
- R3: A divisor of zero gives `done_o`=1 with `fault_o`=1 on the first cycle after the accepting clock edge.
- R4: With `signed_i`=1, a dividend of only the top bit set (0x80000000 at default width) and a divisor of all ones give `done_o`=1 with `fault_o`=1 on the first cycle after the accepting edge.
- R5: In unsigned mode, a quotient of 2^W or more (W = half width) sets `fault_o` in the done cycle.
- R6: In signed mode, a quotient outside −2^(W−1) … 2^(W−1)−1 sets `fault_o` in the done cycle.
- R7: `quot_o` and `rem_o` read zero whenever `fault_o` is high or `done_o` is low.
- R8: `done_o` lasts exactly one cycle. For operations not covered by R3 or R4, it appears 2W/STEPS+1 cycles after the accepting edge.
- R9: `start_i` is accepted only when `busy_o` is low. A start pulse during an operation, including its done cycle, has no effect on that result and does not begin a new operation.
- R10: `busy_o` is high from the cycle after acceptance through the done cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Begin an operation when idle |
| signed_i | input | 1 | 1 = two's-complement mode |
| dvd_hi_i | input | W | Upper half of the dividend |
| dvd_lo_i | input | W | Lower half of the dividend |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Divide error, valid with `done_o` |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
The error decision and the result delivery land in the same cycle. The range check is made on the final quotient, in the very cycle `done_o` rises, so the fault and the zeroed outputs must appear together with the completion pulse.

A sweep over every dividend, every divisor and both modes at a four-bit half width produces overflow in both signs next to quotients that just fit. The bench judges each done cycle on the fault flag, the two output words and the latency, all computed arithmetically.

A second collision is a start pulse that arrives during the done cycle. It must leave the block idle afterwards.

// File: rtl/divx_pkg.sv
package divx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divx_state_e;
endpackage

// File: rtl/divx_prep.sv
// Operand preparation: magnitudes, sign bookkeeping and early traps.
module divx_prep #(
  parameter int W = 16
) (
  input  logic            sgn_i,
  input  logic [W-1:0]    hi_i,
  input  logic [W-1:0]    lo_i,
  input  logic [W-1:0]    dvs_i,
  output logic [2*W-1:0]  dvd_mag_o,
  output logic [W-1:0]    dvs_mag_o,
  output logic            q_neg_o,
  output logic            r_neg_o,
  output logic            early_trap_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] dvd;
  logic          dvd_neg;
  logic          dvs_neg;
  logic          div_zero;
  logic          min_case;

  always_comb begin
    dvd       = {hi_i, lo_i};
    dvd_neg   = sgn_i & hi_i[W-1];
    dvs_neg   = sgn_i & dvs_i[W-1];
    dvd_mag_o = dvd_neg ? (DW'(0) - dvd) : dvd;
    dvs_mag_o = dvs_neg ? (W'(0) - dvs_i) : dvs_i;
    q_neg_o   = dvd_neg ^ dvs_neg;
    r_neg_o   = dvd_neg;
    div_zero  = (dvs_i == '0);
    min_case  = sgn_i && (dvd == MOST_NEG) && (dvs_i == '1);
    early_trap_o = div_zero | min_case;
  end
endmodule

// File: rtl/divx_step.sv
// One restoring shift-subtract step on magnitudes.
module divx_step #(
  parameter int W = 16
) (
  input  logic [W-1:0]   part_i,
  input  logic [2*W-1:0] sh_i,
  input  logic [W-1:0]   dvs_i,
  output logic [W-1:0]   part_o,
  output logic [2*W-1:0] sh_o
);
  localparam int DW = 2 * W;

  logic [W:0]   wide;
  logic [W-1:0] diff;
  logic         ge;

  always_comb begin
    wide   = {part_i, sh_i[DW-1]};
    ge     = (wide >= {1'b0, dvs_i});
    diff   = wide[W-1:0] - dvs_i;
    part_o = ge ? diff : wide[W-1:0];
    sh_o   = {sh_i[DW-2:0], ge};
  end
endmodule

// File: rtl/divx_post.sv
// Sign restoration and quotient range check.
module divx_post #(
  parameter int W = 16
) (
  input  logic           sgn_i,
  input  logic [2*W-1:0] q_mag_i,
  input  logic [W-1:0]   r_mag_i,
  input  logic           q_neg_i,
  input  logic           r_neg_i,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic           ovf_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] HALF = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic ovf_u;
  logic ovf_s;

  always_comb begin
    ovf_u  = |q_mag_i[DW-1:W];
    ovf_s  = q_neg_i ? (q_mag_i > HALF) : (q_mag_i >= HALF);
    ovf_o  = sgn_i ? ovf_s : ovf_u;
    quot_o = q_neg_i ? (W'(0) - q_mag_i[W-1:0]) : q_mag_i[W-1:0];
    rem_o  = r_neg_i ? (W'(0) - r_mag_i) : r_mag_i;
  end
endmodule

// File: rtl/divx_unit.sv
// Double-by-single width integer divider with divide-error detection.
module divx_unit #(
  parameter int W     = 16,
  parameter int STEPS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         fault_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  import divx_pkg::*;

  localparam int DW   = 2 * W;
  localparam int NCYC = DW / STEPS;
  localparam int CW   = $clog2(NCYC + 1);

  // state registers
  divx_state_e    st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [W-1:0]   part_q, part_d;
  logic [W-1:0]   dvs_q, dvs_d;
  logic           sgn_q, sgn_d;
  logic           qneg_q, qneg_d;
  logic           rneg_q, rneg_d;
  logic           trap_q, trap_d;
  logic           ld_en;

  // operand preparation
  logic [DW-1:0]  p_dvd_mag;
  logic [W-1:0]   p_dvs_mag;
  logic           p_qneg;
  logic           p_rneg;
  logic           p_trap;
  logic           accept;

  divx_prep #(.W(W)) u_prep (
    .sgn_i        (signed_i),
    .hi_i         (dvd_hi_i),
    .lo_i         (dvd_lo_i),
    .dvs_i        (dvs_i),
    .dvd_mag_o    (p_dvd_mag),
    .dvs_mag_o    (p_dvs_mag),
    .q_neg_o      (p_qneg),
    .r_neg_o      (p_rneg),
    .early_trap_o (p_trap)
  );

  // chain of STEPS shift-subtract stages per cycle
  logic [W-1:0]  ch_part [STEPS+1];
  logic [DW-1:0] ch_sh   [STEPS+1];

  assign ch_part[0] = part_q;
  assign ch_sh[0]   = sh_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    divx_step #(.W(W)) u_step (
      .part_i (ch_part[g]),
      .sh_i   (ch_sh[g]),
      .dvs_i  (dvs_q),
      .part_o (ch_part[g+1]),
      .sh_o   (ch_sh[g+1])
    );
  end

  // next-state logic
  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    part_d = part_q;
    dvs_d  = dvs_q;
    sgn_d  = sgn_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    trap_d = trap_q;
    ld_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ld_en  = 1'b1;
          sh_d   = p_dvd_mag;
          part_d = '0;
          dvs_d  = p_dvs_mag;
          sgn_d  = signed_i;
          qneg_d = p_qneg;
          rneg_d = p_rneg;
          trap_d = p_trap;
          cnt_d  = CW'(NCYC);
          st_d   = p_trap ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        ld_en  = 1'b1;
        sh_d   = ch_sh[STEPS];
        part_d = ch_part[STEPS];
        cnt_d  = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      part_q <= '0;
      dvs_q  <= '0;
      sgn_q  <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      trap_q <= 1'b0;
    end else if (ld_en) begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      part_q <= part_d;
      dvs_q  <= dvs_d;
      sgn_q  <= sgn_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
      trap_q <= trap_d;
    end
  end

  // result stage
  logic [W-1:0] r_quot;
  logic [W-1:0] r_rem;
  logic         r_ovf;
  logic         fin;
  logic         flt;

  divx_post #(.W(W)) u_post (
    .sgn_i   (sgn_q),
    .q_mag_i (sh_q),
    .r_mag_i (part_q),
    .q_neg_i (qneg_q),
    .r_neg_i (rneg_q),
    .quot_o  (r_quot),
    .rem_o   (r_rem),
    .ovf_o   (r_ovf)
  );

  always_comb begin
    fin     = (st_q == ST_FIN);
    flt     = fin & (trap_q | r_ovf);
    busy_o  = (st_q != ST_IDLE);
    done_o  = fin;
    fault_o = flt;
    quot_o  = (fin & ~flt) ? r_quot : '0;
    rem_o   = (fin & ~flt) ? r_rem  : '0;
  end
endmodule

// File: rtl/divx_unit_chk.sv
module divx_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dvd_hi_i,
  input logic [W-1:0] dvd_lo_i,
  input logic [W-1:0] dvs_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         fault_o,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] rem_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [W-1:0] hi_c, lo_c, dvs_c;
  logic         sgn_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_c  <= '0;
      lo_c  <= '0;
      dvs_c <= '0;
      sgn_c <= 1'b0;
    end else if (start_i && !busy_o) begin
      hi_c  <= dvd_hi_i;
      lo_c  <= dvd_lo_i;
      dvs_c <= dvs_i;
      sgn_c <= signed_i;
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_zero_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && dvs_i == '0) |=> (done_o && fault_o));

  a_r4_min_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && signed_i && {dvd_hi_i, dvd_lo_i} == MOST_NEG && dvs_i == '1)
      |=> (done_o && fault_o));

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r1_unsigned_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && !sgn_c) |->
      (({{W{1'b0}}, quot_o} * {{W{1'b0}}, dvs_c} + {{W{1'b0}}, rem_o}) == {hi_c, lo_c}
       && rem_o < dvs_c));

  a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fault_o && sgn_c && rem_o != '0) |-> (rem_o[W-1] == hi_c[W-1]));
endmodule

bind divx_unit divx_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .signed_i (signed_i),
  .dvd_hi_i (dvd_hi_i),
  .dvd_lo_i (dvd_lo_i),
  .dvs_i    (dvs_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fault_o  (fault_o),
  .quot_o   (quot_o),
  .rem_o    (rem_o)
);

// File: tb/divx_unit_bench.sv
module divx_unit_bench;
  localparam int TW  = 4;
  localparam int TDW = 2 * TW;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          signed_i;
  logic [TW-1:0] dvd_hi_i, dvd_lo_i, dvs_i;
  logic          busy_o, done_o, fault_o;
  logic [TW-1:0] quot_o, rem_o;

  int n_chk;
  int n_bad;
  int cyc;

  divx_unit #(.W(TW), .STEPS(1)) u_divx_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .signed_i (signed_i),
    .dvd_hi_i (dvd_hi_i),
    .dvd_lo_i (dvd_lo_i),
    .dvs_i    (dvs_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fault_o  (fault_o),
    .quot_o   (quot_o),
    .rem_o    (rem_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      summary();
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sx(input int v, input int bits);
    if (v >= (1 << (bits - 1))) return v - (1 << bits);
    return v;
  endfunction

  task automatic run_op(input int hi, input int lo, input int d, input bit sg);
    int  n, q, r, lat, eq, er;
    bit  ef;
    string tag;
    n  = hi * (1 << TW) + lo;
    ef = 1'b0; eq = 0; er = 0;
    lat = TDW + 1;
    if (d == 0) begin
      ef = 1'b1; lat = 1; tag = "R3";
    end else if (sg && n == (1 << (TDW - 1)) && d == (1 << TW) - 1) begin
      ef = 1'b1; lat = 1; tag = "R4";
    end else if (!sg) begin
      q = n / d; r = n % d;
      if (q >= (1 << TW)) begin ef = 1'b1; tag = "R5"; end
      else begin eq = q; er = r; tag = "R1"; end
    end else begin
      q = sx(n, TDW) / sx(d, TW);
      r = sx(n, TDW) % sx(d, TW);
      if (q > (1 << (TW - 1)) - 1 || q < -(1 << (TW - 1))) begin ef = 1'b1; tag = "R6"; end
      else begin eq = q & ((1 << TW) - 1); er = r & ((1 << TW) - 1); tag = "R2"; end
    end
    dvd_hi_i = TW'(hi); dvd_lo_i = TW'(lo); dvs_i = TW'(d); signed_i = sg;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    check("R10", "busy after accept", int'(busy_o), 1);
    begin
      int k;
      k = 1;
      while (!done_o && k < 100) begin
        @(posedge clk); #1;
        k++;
      end
      check("R8", "latency", k, lat);
    end
    check(tag, "fault", int'(fault_o), int'(ef));
    check(ef ? "R7" : tag, "quotient", int'(quot_o), eq);
    check(ef ? "R7" : tag, "remainder", int'(rem_o), er);
    @(posedge clk); #1;
    check("R8", "done pulse width", int'(done_o), 0);
    check("R10", "busy after done", int'(busy_o), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0;
    dvd_hi_i = '0; dvd_lo_i = '0; dvs_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "reset busy", int'(busy_o), 0);
    check("R8", "reset done", int'(done_o), 0);
    check("R7", "reset fault/quot/rem", int'(fault_o) + int'(quot_o) + int'(rem_o), 0);

    // R9: start pulses during an operation and in its done cycle are ignored
    dvd_hi_i = '0; dvd_lo_i = 4'd13; dvs_i = 4'd3; signed_i = 1'b0;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    dvs_i = '0; dvd_hi_i = 4'hF; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    begin
      int k;
      k = 0;
      while (!done_o && k < 100) begin @(posedge clk); #1; k++; end
    end
    check("R9", "fault after mid-run start", int'(fault_o), 0);
    check("R9", "quotient after mid-run start", int'(quot_o), 4);
    check("R9", "remainder after mid-run start", int'(rem_o), 1);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    check("R9", "busy after start in done cycle", int'(busy_o), 0);
    @(posedge clk); #1;
    check("R9", "done after start in done cycle", int'(done_o), 0);

    // exhaustive sweep, both modes
    for (int sg = 0; sg < 2; sg++)
      for (int d = 0; d < (1 << TW); d++)
        for (int n = 0; n < (1 << TDW); n++)
          run_op(n >> TW, n & ((1 << TW) - 1), d, sg[0]);

    summary();
  end
endmodule